// File: doc/BRIEF.md
# Fractional-Increment Real-Time Counter

A free-running 64-bit counter that advances at one fixed nominal rate (6.144 MHz) whatever the frequency of the reference clock driving it. On every reference clock a phase accumulator adds a programmable numerator. When the running sum reaches the programmable denominator, the denominator is taken off and the counter steps by one. The counter therefore advances by numerator/denominator per clock on average. Typical settings are 4/25 for a 38.4 MHz reference (the reset default), 8/25 for 19.2 MHz, and 64/125, 768/1625, 384/1625 or 256/1125 for other references.

Software programs the ratio through two 32-bit registers. Only the low 12 bits of each register form the ratio. The upper bits are stored and read back unchanged, so read-modify-write is safe. When the reference source changes, software rewrites the ratio. The residue in the accumulator is kept, so the count never steps back or skips.

The phase logic has two named states. RUN adds and wraps. HALT holds the accumulator while the effective denominator is zero. Two transitions are named: STOP (RUN to HALT) is taken when a zero denominator becomes effective, and RESUME (HALT to RUN) is taken when a non-zero denominator becomes effective.

Top module: `rtc_frac`

## Requirements
- R1: After reset the count is 0, the accumulator is 0, the numerator register reads 4 and the denominator register reads 25.
- R2: A write to address 0x10 sets the numerator register. A write to address 0x14 sets the denominator register. All 32 written bits read back at the same address from the next cycle.
- R3: Reads are combinational. Address 0x00 returns count bits 31:0 and 0x04 returns bits 63:32. Any address other than 0x00, 0x04, 0x10 and 0x14 reads 0. `count_o` always shows the full count.
- R4: On each clock with a non-zero denominator, the residue plus the numerator is formed. If that sum is at least the denominator, the residue becomes the sum minus the denominator and the count rises by exactly one. Otherwise the residue becomes the sum and the count holds.
- R5: Starting from residue 0 with ratio 4/25, the count after 100 clocks is exactly 16.
- R6: A register write is used from the clock after its write edge; the write edge itself still uses the old ratio. A ratio change never clears the residue.
- R7: While the effective denominator is zero (HALT), both the count and the residue hold. On the first clock after a non-zero denominator becomes effective, counting resumes from the held residue.
- R8: Between two clocks the count either holds or rises by exactly one; it never decreases.
- R9: Register bits 31:12 have no effect on the ratio.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Write byte address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 8 | Read byte address |
| rd_data | output | 32 | Read data for rd_addr |
| count_o | output | 64 | Current count |

## Verification
Two events can fall in the same cycle: a ratio write and an accumulator wrap. The bench provokes this by rewriting the numerator or denominator on clocks where the residue is about to cross the denominator. It also writes a zero denominator in the middle of a run. The per-clock reference model applies each write only after it has computed that edge's step. Any design that uses the new ratio early, or that clears the residue, therefore shows a count mismatch within a few clocks of the write.

// File: rtl/rtc_frac_pkg.sv
package rtc_frac_pkg;

    // Address map: these offsets are decoded by software drivers.
    localparam logic [7:0] ADDR_CNT_LO = 8'h00;
    localparam logic [7:0] ADDR_CNT_HI = 8'h04;
    localparam logic [7:0] ADDR_NUM    = 8'h10;
    localparam logic [7:0] ADDR_DEN    = 8'h14;

    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_HALT = 1'b1
    } phase_state_t;

endpackage

// File: rtl/rtc_frac_regs.sv
module rtc_frac_regs #(
    parameter int          DATA_W  = 32,
    parameter int          ADDR_W  = 8,
    parameter logic [31:0] NUM_RST = 32'd4,
    parameter logic [31:0] DEN_RST = 32'd25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] num_q,
    output logic [DATA_W-1:0] den_q,
    output logic [DATA_W-1:0] den_nxt
);
    import rtc_frac_pkg::*;

    logic hit_num, hit_den;

    always_comb begin
        hit_num = wr_en && (wr_addr == ADDR_W'(ADDR_NUM));
        hit_den = wr_en && (wr_addr == ADDR_W'(ADDR_DEN));
        den_nxt = hit_den ? wr_data : den_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            num_q <= DATA_W'(NUM_RST);
            den_q <= DATA_W'(DEN_RST);
        end else begin
            if (hit_num) num_q <= wr_data;
            den_q <= den_nxt;
        end
    end

endmodule

// File: rtl/rtc_frac_phase.sv
module rtc_frac_phase #(
    parameter int          FRAC_W  = 12,
    parameter logic [31:0] DEN_RST = 32'd25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FRAC_W-1:0] num,
    input  logic [FRAC_W-1:0] den,
    input  logic [FRAC_W-1:0] den_nxt,
    output logic              tick
);
    import rtc_frac_pkg::*;

    localparam int ACC_W = FRAC_W + 1;
    localparam int SUM_W = ACC_W + 1;
    localparam phase_state_t ST_RST =
        (DEN_RST[FRAC_W-1:0] == '0) ? ST_HALT : ST_RUN;

    phase_state_t state_q, state_d;
    logic [ACC_W-1:0] acc_q, acc_d;
    logic [SUM_W-1:0] sum;

    // Next state follows the denominator that will be effective next edge.
    always_comb begin
        unique case (state_q)
            ST_RUN:  state_d = (den_nxt == '0) ? ST_HALT : ST_RUN;   // STOP
            ST_HALT: state_d = (den_nxt != '0) ? ST_RUN  : ST_HALT;  // RESUME
            default: state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RST;
        else        state_q <= state_d;
    end

    // Output / datapath process.
    always_comb begin
        sum  = SUM_W'(acc_q) + SUM_W'(num);
        tick = 1'b0;
        acc_d = acc_q;
        unique case (state_q)
            ST_RUN: begin
                if (sum >= SUM_W'(den)) begin
                    tick  = 1'b1;
                    acc_d = ACC_W'(sum - SUM_W'(den));
                end else begin
                    acc_d = ACC_W'(sum);
                end
            end
            ST_HALT: begin
                tick  = 1'b0;
                acc_d = acc_q;
            end
            default: begin
                tick  = 1'b0;
                acc_d = acc_q;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

endmodule

// File: rtl/rtc_frac_count.sv
module rtc_frac_count #(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    output logic [CNT_W-1:0] cnt_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt_q <= '0;
        else if (tick) cnt_q <= cnt_q + CNT_W'(1);
    end
endmodule

// File: rtl/rtc_frac.sv
module rtc_frac #(
    parameter int          DATA_W  = 32,
    parameter int          ADDR_W  = 8,
    parameter int          FRAC_W  = 12,
    parameter int          CNT_W   = 64,
    parameter logic [31:0] NUM_RST = 32'd4,
    parameter logic [31:0] DEN_RST = 32'd25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [CNT_W-1:0]  count_o
);
    import rtc_frac_pkg::*;

    localparam int CNT_WORDS = (CNT_W + DATA_W - 1) / DATA_W;
    localparam int CNT_PAD   = CNT_WORDS * DATA_W;

    logic [DATA_W-1:0]  num_q, den_q, den_nxt;
    logic               tick;
    logic [CNT_W-1:0]   cnt_q;
    logic [CNT_PAD-1:0] cnt_pad;

    rtc_frac_regs #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_RST(NUM_RST), .DEN_RST(DEN_RST)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .num_q(num_q), .den_q(den_q), .den_nxt(den_nxt)
    );

    rtc_frac_phase #(
        .FRAC_W(FRAC_W), .DEN_RST(DEN_RST)
    ) u_phase (
        .clk(clk), .rst_n(rst_n),
        .num(num_q[FRAC_W-1:0]), .den(den_q[FRAC_W-1:0]),
        .den_nxt(den_nxt[FRAC_W-1:0]), .tick(tick)
    );

    rtc_frac_count #(.CNT_W(CNT_W)) u_count (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_q(cnt_q)
    );

    assign cnt_pad = CNT_PAD'(cnt_q);
    assign count_o = cnt_q;

    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_W'(ADDR_NUM))         rd_data = num_q;
        else if (rd_addr == ADDR_W'(ADDR_DEN))    rd_data = den_q;
        else if (rd_addr == ADDR_W'(ADDR_CNT_LO)) rd_data = cnt_pad[DATA_W-1:0];
        else if (rd_addr == ADDR_W'(ADDR_CNT_HI) && CNT_WORDS > 1)
            rd_data = cnt_pad[CNT_PAD-1 -: DATA_W];
    end

endmodule

// File: rtl/rtc_frac_chk.sv
module rtc_frac_chk #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8,
    parameter int FRAC_W = 12,
    parameter int CNT_W  = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [DATA_W-1:0] rd_data,
    input logic [CNT_W-1:0]  count_o
);
    import rtc_frac_pkg::*;

    // R1: count held at zero during reset
    always @(posedge clk) begin
        if (!rst_n) a_r1_reset_zero: assert (count_o == '0);
    end

    // R8 / R4: step of zero or one
    a_r8_monotonic_step: assert property (@(posedge clk) disable iff (!rst_n)
        (count_o == $past(count_o)) || (count_o == $past(count_o) + CNT_W'(1)));

    // R2: written numerator reads back
    a_r2_num_readback: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_W'(ADDR_NUM)) |=>
        ((rd_addr != ADDR_W'(ADDR_NUM)) || (rd_data == $past(wr_data))));

    // R7: zero denominator freezes the count from the following clock
    a_r7_halt_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_W'(ADDR_DEN) && wr_data[FRAC_W-1:0] == '0)
        |=> ##1 $stable(count_o));

    // R3: unmapped address reads zero
    a_r3_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr != ADDR_W'(ADDR_NUM) && rd_addr != ADDR_W'(ADDR_DEN) &&
         rd_addr != ADDR_W'(ADDR_CNT_LO) && rd_addr != ADDR_W'(ADDR_CNT_HI))
        |-> (rd_data == '0));

endmodule

bind rtc_frac rtc_frac_chk #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .FRAC_W(FRAC_W), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .count_o(count_o)
);

// File: tb/sim_rtc_frac.sv
module sim_rtc_frac;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [7:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [63:0] count_o;

    int checks = 0;
    int failures = 0;
    string tag = "R4";

    // reference model state
    logic [31:0] m_num, m_den;
    int          m_acc;
    logic [63:0] m_cnt;

    always #2.5 clk = ~clk;   // 200 MHz

    rtc_frac u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .count_o(count_o)
    );

    // Behavioural model: step with old ratio, then apply the write.
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_num = 32'd4; m_den = 32'd25; m_acc = 0; m_cnt = '0;
        end else begin
            int n, d, s;
            n = int'(m_num & 32'hFFF);
            d = int'(m_den & 32'hFFF);
            if (d != 0) begin
                s = m_acc + n;
                if (s >= d) begin m_acc = (s - d) % 8192; m_cnt = m_cnt + 64'd1; end
                else m_acc = s % 8192;
            end
            if (wr_en && wr_addr == 8'h10) m_num = wr_data;
            if (wr_en && wr_addr == 8'h14) m_den = wr_data;
        end
    end

    function automatic logic [31:0] exp_rd(input logic [7:0] a);
        case (a)
            8'h00:   return m_cnt[31:0];
            8'h04:   return m_cnt[63:32];
            8'h10:   return m_num;
            8'h14:   return m_den;
            default: return 32'd0;
        endcase
    endfunction

    task automatic check(input string t, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", t, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        check(tag, count_o, m_cnt);
        check(tag, {32'd0, rd_data}, {32'd0, exp_rd(rd_addr)});
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic rd_check(input string t, input logic [7:0] a, input logic [31:0] e);
        rd_addr = a;
        #1;
        check(t, {32'd0, rd_data}, {32'd0, e});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check("R1", count_o, 64'd0);
        rd_check("R1", 8'h10, 32'd4);
        rd_check("R1", 8'h14, 32'd25);
        rd_addr = 8'h00;

        // R5 default rate
        tag = "R5";
        repeat (100) tick();
        check("R5", count_o, 64'd16);

        // R9, R2, R6: upper bits stored, ignored for ratio
        tag = "R6";
        wr(8'h10, 32'hABCDE008);
        wr(8'h14, 32'hFFFFF019);
        rd_check("R2", 8'h10, 32'hABCDE008);
        rd_check("R2", 8'h14, 32'hFFFFF019);
        rd_addr = 8'h00;
        tag = "R9";
        repeat (250) tick();
        check("R9", count_o, 64'd96);

        // R7 halt with zero denominator, then resume with residue
        tag = "R7";
        wr(8'h14, 32'h0);
        repeat (50) tick();
        check("R7", count_o, 64'd96);
        wr(8'h14, 32'd25);
        check("R7", count_o, 64'd96);
        tick();
        check("R7", count_o, 64'd97);

        // R4 / R6: ratio sweep with writes landing on wrap cycles
        tag = "R4";
        wr(8'h10, 32'd64);   wr(8'h14, 32'd125);  repeat (300) tick();
        tag = "R6";
        wr(8'h14, 32'd1625); wr(8'h10, 32'd768);  repeat (300) tick();
        wr(8'h10, 32'd384);                       repeat (300) tick();
        wr(8'h10, 32'd256);  wr(8'h14, 32'd1125); repeat (300) tick();
        for (int i = 0; i < 40; i++) begin
            wr(8'h10, (i % 2 == 0) ? 32'd8 : 32'd4);
            wr(8'h14, (i % 3 == 0) ? 32'd25 : 32'd9);
            tick();
        end

        // R3 read map
        rd_check("R3", 8'h08, 32'd0);
        rd_check("R3", 8'hFF, 32'd0);
        rd_check("R3", 8'h04, m_cnt[63:32]);
        rd_check("R3", 8'h00, m_cnt[31:0]);
        tag = "R8";
        repeat (20) tick();

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule